// File: doc/BRIEF.md
# E1 Transmit Spare-Bit Stack Inserter

This block stores the national spare bits that an E1 framer places in the Sa4 to Sa8 positions of time slot 0. A host fills a stack of ten byte registers: a pair for each spare-bit position, 80 bits in all. At every window boundary the block copies the stack into a shadow store. Over the next 32 frames it hands one bit per spare-bit position to the time slot 0 generator on every odd (non-frame-alignment) frame.

A frame strobe advances a 5-bit frame index. When the framer runs with CRC-4, a double-multiframe start pulse fixes the phase of the window. Without CRC-4 the window runs freely from reset. A ready flag rises when a new window opens, and a status read clears it. If the host writes nothing during a window, the previous contents go out again. An interrupt follows the ready flag. It is gated by an enable and held off while frame or multiframe alignment is lost.

Top module: `e1_sa_tx_stack`

## Requirements
- R1: After reset, frame_idx is 0, stack_ready and irq are 0, and every stack and shadow register holds 8'hFF, so sa_bits is 5'b11111.
- R2: Each cycle with frame_stb high (and no alignment under R10) advances frame_idx by one, wrapping from 31 to 0. frame_idx is unchanged in cycles without frame_stb.
- R3: While frame_idx is even, sa_bits is 5'b11111.
- R4: While frame_idx = f is odd, sa_bits[k] (k = 0 for Sa4 up to k = 4 for Sa8) is bit 7 − f[3:1] of shadow register 2k + f[4]. Stack address 2k holds frames 1..15 and address 2k+1 holds frames 17..31, with the most significant bit sent first.
- R5: The shadow store loads the whole stack only at a window boundary. Data written during a window appears on sa_bits only after the next boundary, and sa_bits never changes in a cycle without frame_stb.
- R6: A host write in the same cycle as a boundary is not in the shadow copy taken at that boundary. It goes out in the window after.
- R7: A window in which the host writes nothing repeats the previous window's bits unchanged.
- R8: stack_ready rises at every window boundary and falls on stat_rd. When stat_rd and a boundary fall in the same cycle, stack_ready stays high.
- R9: irq is high exactly when stack_ready and irq_en are high and align_loss is low.
- R10: With crc4_en high, frame_stb with dmf_start is a boundary that sets frame_idx to 0. Reaching index 31 is then not a boundary. With crc4_en low, dmf_start is ignored and the boundary is the strobe at frame_idx 31.
- R11: Writes to addresses 10 to 15 change no stack register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse at each frame end |
| dmf_start | input | 1 | Double-multiframe start, used with frame_stb when crc4_en is high |
| crc4_en | input | 1 | CRC-4 alignment of the window |
| align_loss | input | 1 | Frame or multiframe alignment lost; suppresses irq |
| irq_en | input | 1 | Interrupt enable |
| reg_we | input | 1 | Stack write strobe |
| reg_addr | input | 4 | Stack register address (0..9 valid) |
| reg_wdata | input | 8 | Stack write data |
| stat_rd | input | 1 | Status read; clears stack_ready |
| frame_idx | output | 5 | Current frame index in the window |
| sa_bits | output | 5 | Sa4..Sa8 bits for the current frame (bit 0 = Sa4) |
| stack_ready | output | 1 | A new window is open for host writes |
| irq | output | 1 | Gated stack interrupt |

## Verification
The hardest cases to reach are the collisions at the window boundary. One is a host write that lands in the very cycle the shadow copy is taken. The other is a status read that coincides with the ready flag being set again. The bench drives the write strobe and the status read together with the frame strobe at index 31, or together with a double-multiframe pulse in the middle of a window. It then sweeps two further windows to show the write is deferred and then repeated. The stack is filled with distinct per-register bytes, so a wrong bit order or a wrong register pairing shows up at one particular frame.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
    localparam int SA_COUNT = 5;
    localparam int HALVES   = 2;
    localparam int NUM_REGS = SA_COUNT * HALVES;
    localparam int REG_W    = 8;
    localparam int FRAMES   = 32;
    localparam int IDX_W    = $clog2(FRAMES);
    localparam int ADDR_W   = 4;

    typedef logic [REG_W-1:0]    sa_byte_t;
    typedef sa_byte_t [NUM_REGS-1:0] stack_t;
    typedef logic [SA_COUNT-1:0] sa_vec_t;
    typedef logic [IDX_W-1:0]    fidx_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        sa_byte_t          data;
    } host_wr_t;

    typedef enum logic [1:0] {
        WIN_HOLD  = 2'd0,
        WIN_WRAP  = 2'd1,
        WIN_ALIGN = 2'd2
    } win_evt_e;

    // Odd frame f: half chosen by f's top bit, bit position by the next bits, MSB first
    function automatic logic pick_bit(input stack_t s, input int sa, input fidx_t f);
        int reg_i;
        int bit_i;
        reg_i = sa * HALVES + int'(f[IDX_W-1]);
        bit_i = (REG_W - 1) - int'(f[IDX_W-2:1]);
        return s[reg_i][bit_i];
    endfunction
endpackage

// File: rtl/e1sa_frame_ctr.sv
module e1sa_frame_ctr
    import e1sa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_stb,
    input  logic  crc4_en,
    input  logic  dmf_start,
    output fidx_t frame_idx,
    output logic  load_stack
);
    localparam fidx_t LAST_IDX = fidx_t'(FRAMES - 1);

    win_evt_e evt;

    always_comb begin
        evt = WIN_HOLD;
        if (frame_stb) begin
            if (crc4_en) begin
                if (dmf_start) evt = WIN_ALIGN;
            end else if (frame_idx == LAST_IDX) begin
                evt = WIN_WRAP;
            end
        end
    end

    assign load_stack = (evt != WIN_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_idx <= '0;
        end else if (frame_stb) begin
            if (evt == WIN_ALIGN) frame_idx <= '0;
            else                  frame_idx <= frame_idx + fidx_t'(1);
        end
    end
endmodule

// File: rtl/e1sa_reg_file.sv
module e1sa_reg_file
    import e1sa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_wr_t wr,
    output stack_t   regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '1;
            end else if (wr.we && (wr.addr == ADDR_W'(g))) begin
                regs[g] <= wr.data;
            end
        end
    end
endmodule

// File: rtl/e1sa_shadow_sel.sv
module e1sa_shadow_sel
    import e1sa_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_stack,
    input  stack_t  regs,
    input  fidx_t   frame_idx,
    output sa_vec_t sa_bits
);
    stack_t shadow;

    always_ff @(posedge clk) begin
        if (rst)             shadow <= '1;
        else if (load_stack) shadow <= regs;
    end

    for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
        always_comb begin
            if (frame_idx[0]) sa_bits[k] = pick_bit(shadow, k, frame_idx);
            else              sa_bits[k] = 1'b1;
        end
    end
endmodule

// File: rtl/e1sa_ready_ctl.sv
module e1sa_ready_ctl (
    input  logic clk,
    input  logic rst,
    input  logic load_stack,
    input  logic stat_rd,
    input  logic irq_en,
    input  logic align_loss,
    output logic stack_ready,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)             stack_ready <= 1'b0;
        else if (load_stack) stack_ready <= 1'b1;
        else if (stat_rd)    stack_ready <= 1'b0;
    end

    assign irq = stack_ready & irq_en & ~align_loss;
endmodule

// File: rtl/e1_sa_tx_stack.sv
module e1_sa_tx_stack
    import e1sa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              dmf_start,
    input  logic              crc4_en,
    input  logic              align_loss,
    input  logic              irq_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              stat_rd,
    output logic [IDX_W-1:0]  frame_idx,
    output logic [SA_COUNT-1:0] sa_bits,
    output logic              stack_ready,
    output logic              irq
);
    logic     load_stack;
    stack_t   regs;
    host_wr_t wr;

    assign wr = '{we: reg_we, addr: reg_addr, data: reg_wdata};

    e1sa_frame_ctr u_ctr (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .crc4_en(crc4_en),
        .dmf_start(dmf_start), .frame_idx(frame_idx), .load_stack(load_stack)
    );

    e1sa_reg_file u_regs (
        .clk(clk), .rst(rst), .wr(wr), .regs(regs)
    );

    e1sa_shadow_sel u_sel (
        .clk(clk), .rst(rst), .load_stack(load_stack), .regs(regs),
        .frame_idx(frame_idx), .sa_bits(sa_bits)
    );

    e1sa_ready_ctl u_rdy (
        .clk(clk), .rst(rst), .load_stack(load_stack), .stat_rd(stat_rd),
        .irq_en(irq_en), .align_loss(align_loss),
        .stack_ready(stack_ready), .irq(irq)
    );
endmodule

// File: rtl/e1_sa_tx_stack_chk.sv
module e1_sa_tx_stack_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_stb,
    input logic       dmf_start,
    input logic       crc4_en,
    input logic       align_loss,
    input logic       irq_en,
    input logic       stat_rd,
    input logic [4:0] frame_idx,
    input logic [4:0] sa_bits,
    input logic       stack_ready,
    input logic       irq
);
    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(frame_idx));

    assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !crc4_en) |=> frame_idx == $past(frame_idx) + 5'd1);

    assert_even_ones_R3: assert property (@(posedge clk) disable iff (rst)
        !frame_idx[0] |-> sa_bits == 5'h1F);

    assert_sa_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(sa_bits));

    assert_ready_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stack_ready) |-> $past(frame_stb));

    assert_ready_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !frame_stb) |=> !stack_ready);

    assert_irq_src_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> stack_ready);

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (align_loss || !irq_en) |-> !irq);

    assert_align_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (crc4_en && frame_stb && dmf_start) |=> frame_idx == 5'd0);
endmodule

bind e1_sa_tx_stack e1_sa_tx_stack_chk u_chk (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .dmf_start(dmf_start),
    .crc4_en(crc4_en), .align_loss(align_loss), .irq_en(irq_en),
    .stat_rd(stat_rd), .frame_idx(frame_idx), .sa_bits(sa_bits),
    .stack_ready(stack_ready), .irq(irq)
);

// File: tb/e1_sa_tx_stack_test.sv
module e1_sa_tx_stack_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0, dmf_start = 1'b0, crc4_en = 1'b0;
    logic       align_loss = 1'b0, irq_en = 1'b0;
    logic       reg_we = 1'b0, stat_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [4:0] frame_idx, sa_bits;
    logic       stack_ready, irq;

    always #2 clk = ~clk;

    e1_sa_tx_stack uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .dmf_start(dmf_start),
        .crc4_en(crc4_en), .align_loss(align_loss), .irq_en(irq_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .stat_rd(stat_rd), .frame_idx(frame_idx), .sa_bits(sa_bits),
        .stack_ready(stack_ready), .irq(irq)
    );

    typedef struct {
        int         idx;
        logic [4:0] sa;
        logic       rdy;
    } exp_t;

    exp_t       q[$];
    int         n_checks = 0, n_fail = 0;
    bit         finished = 1'b0;
    logic [7:0] m_regs[10];
    logic [7:0] m_shadow[10];
    int         m_idx = 0;
    logic       m_ready = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_sa();
        logic [4:0] v = 5'h1F;
        if (m_idx % 2 == 1)
            for (int k = 0; k < 5; k++)
                v[k] = m_shadow[2*k + m_idx/16][7 - (m_idx % 16)/2];
        return v;
    endfunction

    // Driver: one cycle of stimulus, update the model, push the expected outputs
    task automatic drive(input bit stb, input bit dmf, input bit we, input int addr,
                         input logic [7:0] data, input bit rd);
        bit bnd;
        exp_t e;
        @(negedge clk);
        frame_stb = stb; dmf_start = dmf; reg_we = we;
        reg_addr = 4'(addr); reg_wdata = data; stat_rd = rd;
        bnd = stb && (crc4_en ? dmf : (m_idx == 31));
        if (bnd) for (int i = 0; i < 10; i++) m_shadow[i] = m_regs[i];
        if (we && addr < 10) m_regs[addr] = data;
        if (stb) m_idx = (crc4_en && dmf) ? 0 : (m_idx + 1) % 32;
        if (bnd) m_ready = 1'b1;
        else if (rd) m_ready = 1'b0;
        @(negedge clk);
        frame_stb = 0; dmf_start = 0; reg_we = 0; stat_rd = 0;
        e.idx = m_idx; e.sa = exp_sa(); e.rdy = m_ready;
        q.push_back(e);
    endtask

    task automatic step(); drive(1, 0, 0, 0, 8'h00, 0); endtask
    task automatic wr(input int a, input logic [7:0] d); drive(0, 0, 1, a, d, 0); endtask
    task automatic run_to(input int target);
        while (m_idx != target) step();
    endtask

    // Monitor: compare the design's outputs against each expected item
    initial begin
        exp_t e;
        forever begin
            wait (q.size() > 0);
            e = q.pop_front();
            check(frame_idx == 5'(e.idx), "R2 frame index", frame_idx, e.idx);
            check(sa_bits == e.sa, (e.idx % 2) ? "R4 odd-frame Sa bits" : "R3 even-frame ones",
                  sa_bits, e.sa);
            check(stack_ready == e.rdy, "R8 ready flag", stack_ready, e.rdy);
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 10; i++) begin m_regs[i] = 8'hFF; m_shadow[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(frame_idx == 0, "R1 idx", frame_idx, 0);
        check(sa_bits == 5'h1F, "R1 sa", sa_bits, 5'h1F);
        check(stack_ready == 0, "R1 ready", stack_ready, 0);
        check(irq == 0, "R1 irq", irq, 0);

        // R5 writes in window 0 stay invisible until the boundary
        for (int i = 0; i < 10; i++) wr(i, 8'(i * 37 + 5));
        wr(12, 8'h00);                       // R11 ignored address
        drive(1, 1, 0, 0, 8'h00, 0);         // R10 dmf ignored without CRC-4
        run_to(0);
        // R4 pattern A sweep, plus a new pattern with a write on the boundary
        for (int i = 0; i < 10; i++) wr(i, 8'(8'hA5 ^ (i * 19)));
        wr(15, 8'h00);                       // R11
        run_to(31);
        drive(1, 0, 1, 0, 8'h3C, 0);         // R6 write in the boundary cycle
        run_to(31);
        step();                              // R6 deferred byte now loaded
        run_to(0);
        run_to(31);
        step();                              // R7 unchanged re-send
        for (int i = 0; i < 10; i++) wr(i, 8'(1 << (i % 8)));

        // R9 irq gating
        irq_en = 1; @(negedge clk);
        check(irq == 1, "R9 irq on", irq, 1);
        align_loss = 1; @(negedge clk);
        check(irq == 0, "R9 irq masked by alignment loss", irq, 0);
        align_loss = 0;
        drive(0, 0, 0, 0, 8'h00, 1);         // R8 read clears
        @(negedge clk);
        check(irq == 0, "R9 irq after read", irq, 0);

        // R8 read coinciding with a boundary keeps the flag set
        run_to(31);
        drive(1, 0, 0, 0, 8'h00, 1);
        @(negedge clk);
        check(stack_ready == 1, "R8 set wins over read", stack_ready, 1);
        check(irq == 1, "R9 irq follows ready", irq, 1);
        drive(0, 0, 0, 0, 8'h00, 1);

        // R10 CRC-4 alignment mid-window
        crc4_en = 1;
        run_to(10);
        for (int i = 0; i < 10; i++) wr(i, 8'(i * 91 + 3));
        drive(1, 1, 1, 4, 8'h0F, 0);         // R10 align, R6 write same cycle
        @(negedge clk);
        check(frame_idx == 0, "R10 align to zero", frame_idx, 0);
        run_to(31);
        drive(0, 0, 0, 0, 8'h00, 1);
        step();                              // R10 index 31 is no boundary now
        @(negedge clk);
        check(stack_ready == 0, "R10 no load at wrap under CRC-4", stack_ready, 0);
        run_to(5);
        drive(1, 1, 0, 0, 8'h00, 0);
        run_to(31);

        wait (q.size() == 0);
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule